// File: doc/BRIEF.md
# Smart Panel Parallel Bus Sequencer

This block runs single-byte transfers to a display module that has its own controller and frame memory, over an 8-bit parallel data bus with one enable strobe. The host programs two timing values through a small register port: a preload for a down counter and a strobe threshold. Writing the control register starts a transfer. While the counter runs down to zero, the strobe goes high once the count falls to the threshold. It drops one clock before the count reaches zero, so in a write the data byte stays on the bus for one extra clock of hold time.

In a read transfer the bus is released and the strobe keeps the same timing. The incoming byte is sampled at the edge that ends the last strobe-active clock and lands in the data field, where the host reads it back. The panel's register-select and direction lines are driven by software through general-purpose pins and are not part of this block.

Top module: `spanel_seq`

## Requirements
- R1: Register address 0 reads back the counter preload in bits [7:0] and the strobe threshold in bits [15:8]. Both fields can be written and read, and all other bits read as zero.
- R2: A write to address 1 while idle starts a transfer and loads the preload into the counter. The busy flag (address 1, bit 16) is then high for preload+1 clocks while the counter steps down by one each clock to zero.
- R3: When the threshold is nonzero and not above the preload, the strobe is high exactly while the count is at or below the threshold and above zero. It therefore falls one clock before the count reaches zero.
- R4: A transfer started with a zero threshold, or with a threshold greater than the preload, never raises the strobe.
- R5: In a write transfer (address 1, bit 8 = 0) the bus is driven with the data byte (bits [7:0] of the start write) for every busy clock, including the clock with count zero.
- R6: In a read transfer (bit 8 = 1) the bus is never driven and the strobe keeps the R3/R4 timing. The input byte is captured into the data field at the edge where the count steps from 1 to 0.
- R7: A write to address 1 while busy is ignored: data, mode and the running transfer's timing are left unchanged.
- R8: Writes to address 0 during a transfer do not alter that transfer's timing. They take effect from the next start.
- R9: After reset all fields and the busy flag are zero, the strobe is low and the bus is not driven.
- R10: Address 1 reads back the data byte in bits [7:0], the read mode in bit 8 and busy in bit 16, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 1 | Register select: 0 timing, 1 control/data |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data for host_addr |
| pe | output | 1 | Panel enable strobe |
| pbus_out | output | 8 | Bus data driven toward the panel |
| pbus_oe | output | 1 | Bus output enable |
| pbus_in | input | 8 | Bus data returned by the panel |

## Verification
A counter that is off by one shows up at once as a strobe edge in the wrong clock, or as a busy flag that lasts one clock too long or too short. The bench compares both in every clock. A wrong mode or data register shows up as a bus driven during a read, or as wrong bytes on the bus in the first busy clock. A capture taken at the wrong edge returns a byte from a neighbouring clock, because the returned bus value changes every cycle. That byte is seen on the first host read after the transfer.

// File: rtl/spanel_seq.sv
module spanel_seq #(
  parameter int CW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic          host_addr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  output logic          pe,
  output logic [DW-1:0] pbus_out,
  output logic          pbus_oe,
  input  logic [DW-1:0] pbus_in
);
  localparam int THR_LSB  = 8;
  localparam int MODE_BIT = 8;
  localparam int BUSY_BIT = 16;

  logic [CW-1:0] pre_r, thr_r, cnt, thr_l;
  logic [DW-1:0] data_r;
  logic          rd_r, busy, en_ok;
  logic          start;

  assign start    = host_we && host_addr && !busy;
  assign pe       = busy && en_ok && (cnt != '0) && (cnt <= thr_l);
  assign pbus_oe  = busy && !rd_r;
  assign pbus_out = data_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_r <= '0;
      thr_r <= '0;
    end else if (host_we && !host_addr) begin
      pre_r <= host_wdata[CW-1:0];
      thr_r <= host_wdata[THR_LSB +: CW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      thr_l  <= '0;
      en_ok  <= 1'b0;
      data_r <= '0;
      rd_r   <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      cnt    <= pre_r;
      thr_l  <= thr_r;
      en_ok  <= (thr_r != '0) && (thr_r <= pre_r);
      data_r <= host_wdata[DW-1:0];
      rd_r   <= host_wdata[MODE_BIT];
    end else if (busy) begin
      if (rd_r && cnt == CW'(1)) data_r <= pbus_in;
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (!host_addr) begin
      host_rdata[CW-1:0]        = pre_r;
      host_rdata[THR_LSB +: CW] = thr_r;
    end else begin
      host_rdata[DW-1:0]     = data_r;
      host_rdata[MODE_BIT]   = rd_r;
      host_rdata[BUSY_BIT]   = busy;
    end
  end
endmodule

// File: rtl/spanel_seq_chk.sv
module spanel_seq_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic [CW-1:0] cnt,
  input logic          pe,
  input logic          pbus_oe,
  input logic          host_we,
  input logic          host_addr,
  input logic          rd_r
);
  // R3
  strobe_before_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pe |-> cnt != '0);

  // R5
  drive_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pbus_oe |-> busy);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - CW'(1)));

  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == '0) |=> !busy);

  // R7
  ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0 && host_we && host_addr) |=> $stable(rd_r));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!pe && !pbus_oe));
endmodule

bind spanel_seq spanel_seq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cnt(cnt), .pe(pe),
  .pbus_oe(pbus_oe), .host_we(host_we), .host_addr(host_addr), .rd_r(rd_r)
);

// File: tb/spanel_seq_test.sv
module spanel_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic        host_addr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        pe, pbus_oe;
  logic [7:0]  pbus_out;
  logic [7:0]  pbus_in = '0;

  always #10 clk = ~clk;

  spanel_seq uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .pe(pe),
    .pbus_out(pbus_out), .pbus_oe(pbus_oe), .pbus_in(pbus_in)
  );

  int vecs = 0, bad = 0;
  bit done = 0, reset_phase = 1;
  int m_pre = 0, m_thr = 0, m_data = 0, m_rd = 0, m_busy = 0, m_cnt = 0;
  int m_thrl = 0, m_ok = 0;

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit we, input bit addr, input logic [31:0] wd);
    int pin;
    bit epe, eoe;
    logic [31:0] erd;
    @(negedge clk);
    vecs++;
    epe = m_busy && m_ok && m_cnt > 0 && m_cnt <= m_thrl;
    eoe = m_busy && !m_rd;
    if (!host_addr) erd = m_pre | (m_thr << 8);
    else            erd = m_data | (m_rd << 8) | (m_busy << 16);
    if (reset_phase) begin
      cmp("R9 strobe", {31'b0, pe}, {31'b0, epe});
      cmp("R9 drive", {31'b0, pbus_oe}, {31'b0, eoe});
      cmp("R9 regs", host_rdata, erd);
    end else begin
      cmp(m_ok ? "R3 strobe" : "R4 strobe", {31'b0, pe}, {31'b0, epe});
      cmp("R5/R6 drive", {31'b0, pbus_oe}, {31'b0, eoe});
      if (eoe) cmp("R5 data", {24'b0, pbus_out}, m_data);
      cmp(host_addr ? "R2/R6/R7/R10 ctrl" : "R1/R8 timing", host_rdata, erd);
    end
    pin = $urandom & 255;
    host_we = we; host_addr = addr; host_wdata = wd; pbus_in = pin[7:0];
    if (we && addr && !m_busy) begin
      m_busy = 1; m_cnt = m_pre; m_thrl = m_thr;
      m_ok = (m_thr != 0 && m_thr <= m_pre);
      m_data = wd & 255; m_rd = wd[8];
    end else if (m_busy) begin
      if (m_rd && m_cnt == 1) m_data = pin;
      if (m_cnt == 0) m_busy = 0;
      else m_cnt--;
    end
    if (we && !addr) begin
      m_pre = wd & 255; m_thr = (wd >> 8) & 255;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 1'(i % 3 == 0), 32'h0);
  endtask

  task automatic cfg(input int pre, input int thr);
    step(1, 0, 32'hFFFF_0000 | (thr << 8) | pre);
  endtask

  task automatic go(input int data, input bit rd);
    step(1, 1, 32'hFEFE_FE00 & ~32'h100 | (rd << 8) | data);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0); step(0, 1, 0); step(0, 0, 0);
    reset_phase = 0;
    cfg(6, 3); go(8'hA5, 0); idle(9);          // R3 R5
    cfg(4, 2); go(8'h00, 1); idle(8);          // R6
    cfg(3, 5); go(8'h3C, 0); idle(6);          // R4
    cfg(5, 0); go(8'h77, 1); idle(8);          // R4 R6
    cfg(0, 0); go(8'h81, 0); idle(3);          // R2
    cfg(1, 1); go(8'h12, 1); idle(4);          // R6
    cfg(6, 2); go(8'h11, 0); go(8'h22, 1);     // R7
    cfg(2, 1); idle(2);                         // R8
    for (int i = 0; i < 14; i++) go(i, 1'(i % 2)); // R7 at the boundary
    idle(4);
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 6;
      if (r == 0)      cfg($urandom % 12, $urandom % 14);
      else if (r == 1) step(1, 1, $urandom);
      else             step(0, 1'($urandom % 2), $urandom);
    end
    idle(20);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++;
      $display("watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule